// File: doc/BRIEF.md
# USB Host Wrapper Control and Interrupt Register Block

This block is the 32-bit memory-mapped register file that sits beside a USB host controller. It holds the static configuration that the surrounding controller reads as plain wires: a 4-bit bus filter bypass, five port strap bits, a 6-bit frame length adjustment, a byte order select, a coherency select and a bus master enable. It also holds a slave error enable bit and one spare 32-bit scratch register.

An interrupt group combines two event sources into one level-sensitive interrupt line. Bit 0 is the address decode error and bit 1 is the host system error. Status bits are set by single-cycle pulses from hardware, and software clears them by writing ones. Software cannot write the mask directly. It clears mask bits through a write-only unmask register and sets them through a write-only mask-set register.

The bus carries one access per cycle, always full 32-bit words in little-endian order. Read data and the error response are valid in the same cycle as the select. A write takes effect at the next clock edge. An access to any offset that is not mapped, or that is not word aligned, returns zero and raises the decode error event.

Top module: `usbctl_csr_top`

## Requirements
- R1: After reset, frame length adjust is 0x20, bus master enable is 1, the interrupt mask (0x68) reads 0x3, every other register and output is 0, and the interrupt line is low.
- R2: Writes to the bus filter (0x30, 4 bits), port (0x34, 5 bits), frame adjust (0x38, 6 bits), byte order (0x40, bit 0), coherency (0x44, bit 0), bus master enable (0x48, bit 0) and register control (0x60, bit 0) store only the listed bits. Reserved bits read as zero. The matching output pins take the new value one cycle after the write.
- R3: The spare register at 0x78 stores and returns all 32 bits.
- R4: At interrupt status (0x64), writing 1 to a bit clears it and writing 0 leaves it unchanged. Bit 0 is the address decode error and bit 1 is the host system error.
- R5: A one-cycle pulse on an event input sets its status bit. If the pulse and a write-one-to-clear of the same bit arrive in the same cycle, the bit ends up set.
- R6: Writing ones to the unmask register (0x6C) clears those mask bits. Writing ones to the mask-set register (0x70) sets them. Both registers read as zero.
- R7: Writes to the mask register (0x68) have no effect.
- R8: The interrupt line is high exactly when some status bit is set and its mask bit is clear.
- R9: An unmapped or misaligned access reads as zero and sets status bit 0. It asserts the error response only while register control bit 0 is 1. Mapped accesses never assert the error response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_err | output | 1 | Error response, same cycle |
| evt_addr_err | input | 1 | Pulse that sets status bit 0 |
| evt_host_err | input | 1 | Pulse that sets status bit 1 |
| cfg_filt_bypass | output | 4 | Bus filter bypass |
| cfg_port_strap | output | 5 | Port straps |
| cfg_frame_adj | output | 6 | Frame length adjust |
| cfg_big_endian | output | 1 | Byte order select |
| cfg_coherent | output | 1 | Coherency select |
| cfg_master_en | output | 1 | Bus master enable |
| irq | output | 1 | Level interrupt |

## Verification
The interrupt path is driven in several ways: an event pulse while masked, the same event after an unmask, clears written with zeros, with the wrong bit and with the right bit, and a clear that lands in the same cycle as a set pulse. Together these separate a mask with inverted polarity, a clear applied to the wrong bits, and a clear that takes priority over a set. The configuration registers are written with all ones and with mixed patterns, which shows whether reserved bits are dropped. Unmapped, misaligned and write accesses are made with the slave error bit off and then on, which shows that the error response is gated while the decode error event is always raised.

// File: rtl/usbctl_pkg.sv
package usbctl_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned BYP_W   = 4;
  localparam int unsigned PORT_W  = 5;
  localparam int unsigned FADJ_W  = 6;
  localparam int unsigned EVT_N   = 2;
  localparam int unsigned EVT_DEC = 0;
  localparam int unsigned EVT_HST = 1;
  localparam logic [FADJ_W-1:0] FADJ_RST = 6'h20;

  localparam int unsigned OFS_FILT = 'h30;
  localparam int unsigned OFS_PORT = 'h34;
  localparam int unsigned OFS_FADJ = 'h38;
  localparam int unsigned OFS_BEND = 'h40;
  localparam int unsigned OFS_COH  = 'h44;
  localparam int unsigned OFS_BME  = 'h48;
  localparam int unsigned OFS_RCTL = 'h60;
  localparam int unsigned OFS_IST  = 'h64;
  localparam int unsigned OFS_IMSK = 'h68;
  localparam int unsigned OFS_IEN  = 'h6C;
  localparam int unsigned OFS_IDIS = 'h70;
  localparam int unsigned OFS_SPR  = 'h78;

  typedef enum logic [3:0] {
    RID_FILT, RID_PORT, RID_FADJ, RID_BEND, RID_COH, RID_BME, RID_RCTL,
    RID_IST, RID_IMSK, RID_IEN, RID_IDIS, RID_SPR, RID_NONE
  } reg_id_e;
endpackage

// File: rtl/usbctl_addr_dec.sv
module usbctl_addr_dec
  import usbctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_id_e           rid
);
  always_comb begin
    rid = RID_NONE;
    if (addr[1:0] == 2'b00) begin
      case (addr)
        ADDR_W'(OFS_FILT): rid = RID_FILT;
        ADDR_W'(OFS_PORT): rid = RID_PORT;
        ADDR_W'(OFS_FADJ): rid = RID_FADJ;
        ADDR_W'(OFS_BEND): rid = RID_BEND;
        ADDR_W'(OFS_COH):  rid = RID_COH;
        ADDR_W'(OFS_BME):  rid = RID_BME;
        ADDR_W'(OFS_RCTL): rid = RID_RCTL;
        ADDR_W'(OFS_IST):  rid = RID_IST;
        ADDR_W'(OFS_IMSK): rid = RID_IMSK;
        ADDR_W'(OFS_IEN):  rid = RID_IEN;
        ADDR_W'(OFS_IDIS): rid = RID_IDIS;
        ADDR_W'(OFS_SPR):  rid = RID_SPR;
        default:           rid = RID_NONE;
      endcase
    end
  end
endmodule

// File: rtl/usbctl_cfg_regs.sv
module usbctl_cfg_regs
  import usbctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  reg_id_e           rid,
  input  logic [DATA_W-1:0] wdata,
  output logic [BYP_W-1:0]  filt_q,
  output logic [PORT_W-1:0] port_q,
  output logic [FADJ_W-1:0] fadj_q,
  output logic              bend_q,
  output logic              coh_q,
  output logic              bme_q,
  output logic              slverr_q,
  output logic [DATA_W-1:0] spare_q
);
  logic [BYP_W-1:0]  filt_d;
  logic [PORT_W-1:0] port_d;
  logic [FADJ_W-1:0] fadj_d;
  logic              bend_d, coh_d, bme_d, slverr_d;
  logic [DATA_W-1:0] spare_d;

  always_comb begin
    filt_d   = filt_q;
    port_d   = port_q;
    fadj_d   = fadj_q;
    bend_d   = bend_q;
    coh_d    = coh_q;
    bme_d    = bme_q;
    slverr_d = slverr_q;
    spare_d  = spare_q;
    if (we) begin
      case (rid)
        RID_FILT: filt_d   = wdata[BYP_W-1:0];
        RID_PORT: port_d   = wdata[PORT_W-1:0];
        RID_FADJ: fadj_d   = wdata[FADJ_W-1:0];
        RID_BEND: bend_d   = wdata[0];
        RID_COH:  coh_d    = wdata[0];
        RID_BME:  bme_d    = wdata[0];
        RID_RCTL: slverr_d = wdata[0];
        RID_SPR:  spare_d  = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q   <= '0;
      port_q   <= '0;
      fadj_q   <= FADJ_RST;
      bend_q   <= 1'b0;
      coh_q    <= 1'b0;
      bme_q    <= 1'b1;
      slverr_q <= 1'b0;
      spare_q  <= '0;
    end else begin
      filt_q   <= filt_d;
      port_q   <= port_d;
      fadj_q   <= fadj_d;
      bend_q   <= bend_d;
      coh_q    <= coh_d;
      bme_q    <= bme_d;
      slverr_q <= slverr_d;
      spare_q  <= spare_d;
    end
  end

  // R2: with no write, every configuration field holds its value
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable({filt_q, port_q, fadj_q, bend_q, coh_q, bme_q, slverr_q, spare_q}));
endmodule

// File: rtl/usbctl_irq_ctrl.sv
module usbctl_irq_ctrl #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hw_set,
  input  logic         clr_we,
  input  logic         en_we,
  input  logic         dis_we,
  input  logic [N-1:0] bits,
  output logic [N-1:0] status_q,
  output logic [N-1:0] mask_q,
  output logic         irq
);
  logic [N-1:0] status_d, mask_d, clr_vec;

  always_comb begin
    clr_vec  = clr_we ? bits : '0;
    status_d = (status_q & ~clr_vec) | hw_set;
    mask_d   = mask_q;
    if (en_we)  mask_d = mask_q & ~bits;
    if (dis_we) mask_d = mask_q | bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
    end
  end

  assign irq = |(status_q & ~mask_q);

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((status_q & $past(hw_set)) == $past(hw_set)));
  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && hw_set == '0) |=> ((status_q & $past(bits)) == '0));
  p_unmask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> ((mask_q & $past(bits)) == '0));
  p_maskset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dis_we |=> ((mask_q & $past(bits)) == $past(bits)));
  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_we && !dis_we) |=> $stable(mask_q));
  p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_we && bits == '1) |=> !irq);
endmodule

// File: rtl/usbctl_csr_top.sv
module usbctl_csr_top
  import usbctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  input  logic              evt_addr_err,
  input  logic              evt_host_err,
  output logic [3:0]        cfg_filt_bypass,
  output logic [4:0]        cfg_port_strap,
  output logic [5:0]        cfg_frame_adj,
  output logic              cfg_big_endian,
  output logic              cfg_coherent,
  output logic              cfg_master_en,
  output logic              irq
);
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  reg_id_e           rid;
  logic              wr_en, miss, slverr_en;
  logic [DATA_W-1:0] spare;
  logic [EVT_N-1:0]  ist, imsk, hw_set;

  usbctl_addr_dec #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .rid(rid));

  assign wr_en = bus_sel && bus_wr;
  assign miss  = bus_sel && (rid == RID_NONE);

  usbctl_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_sync_q), .we(wr_en), .rid(rid), .wdata(bus_wdata),
    .filt_q(cfg_filt_bypass), .port_q(cfg_port_strap), .fadj_q(cfg_frame_adj),
    .bend_q(cfg_big_endian), .coh_q(cfg_coherent), .bme_q(cfg_master_en),
    .slverr_q(slverr_en), .spare_q(spare)
  );

  always_comb begin
    hw_set          = '0;
    hw_set[EVT_DEC] = evt_addr_err | miss;
    hw_set[EVT_HST] = evt_host_err;
  end

  usbctl_irq_ctrl #(.N(EVT_N)) u_irq (
    .clk(clk), .rst_n(rst_sync_q), .hw_set(hw_set),
    .clr_we(wr_en && rid == RID_IST),
    .en_we(wr_en && rid == RID_IEN),
    .dis_we(wr_en && rid == RID_IDIS),
    .bits(bus_wdata[EVT_N-1:0]),
    .status_q(ist), .mask_q(imsk), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (rid)
        RID_FILT: bus_rdata = DATA_W'(cfg_filt_bypass);
        RID_PORT: bus_rdata = DATA_W'(cfg_port_strap);
        RID_FADJ: bus_rdata = DATA_W'(cfg_frame_adj);
        RID_BEND: bus_rdata = DATA_W'(cfg_big_endian);
        RID_COH:  bus_rdata = DATA_W'(cfg_coherent);
        RID_BME:  bus_rdata = DATA_W'(cfg_master_en);
        RID_RCTL: bus_rdata = DATA_W'(slverr_en);
        RID_IST:  bus_rdata = DATA_W'(ist);
        RID_IMSK: bus_rdata = DATA_W'(imsk);
        RID_SPR:  bus_rdata = spare;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign bus_err = miss && slverr_en;

  p_err_gate_r9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    bus_err |-> (slverr_en && rid == RID_NONE));
  p_miss_flags_r9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    miss |=> ist[EVT_DEC]);
endmodule

// File: tb/tb_usbctl_csr_top.sv
module tb_usbctl_csr_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, bus_sel, bus_wr, evt_a, evt_h;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_err, irq, c_bend, c_coh, c_bme;
  logic [3:0]  c_filt;
  logic [4:0]  c_port;
  logic [5:0]  c_fadj;

  usbctl_csr_top #(.ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .evt_addr_err(evt_a), .evt_host_err(evt_h),
    .cfg_filt_bypass(c_filt), .cfg_port_strap(c_port), .cfg_frame_adj(c_fadj),
    .cfg_big_endian(c_bend), .cfg_coherent(c_coh), .cfg_master_en(c_bme), .irq(irq)
  );

  typedef struct {
    bit          pins;
    bit          cmp_data;
    logic [31:0] data;
    logic        err;
    logic [18:0] pv;
    string       tag;
  } item_t;

  item_t q[$];
  int    errors = 0, checks = 0;
  logic  probe = 1'b0;

  // pin vector: {irq, master_en, coherent, big_endian, frame_adj, port, filt}
  localparam logic [17:0] CFG_RST = {1'b1, 1'b0, 1'b0, 6'h20, 5'h00, 4'h0};
  localparam logic [17:0] CFG_NEW = {1'b0, 1'b1, 1'b1, 6'h15, 5'h0A, 4'hF};

  function automatic void finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endfunction

  // monitor: pops the scoreboard midway through the low clock phase
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (probe && q.size() > 0) begin
        item_t it;
        logic [18:0] act;
        it = q.pop_front();
        checks++;
        act = {irq, c_bme, c_coh, c_bend, c_fadj, c_port, c_filt};
        if (it.pins) begin
          if (act !== it.pv) begin
            errors++;
            $display("FAIL %s pins act=%h exp=%h", it.tag, act, it.pv);
          end
        end else if ((it.cmp_data && bus_rdata !== it.data) || bus_err !== it.err) begin
          errors++;
          $display("FAIL %s bus act=%h/%b exp=%h/%b", it.tag, bus_rdata, bus_err, it.data, it.err);
        end
      end
    end
  end

  task automatic idle_after_edge();
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_wr = 1'b0; probe = 1'b0; evt_a = 1'b0; evt_h = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] ev = 2'b00);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    evt_a = ev[0]; evt_h = ev[1];
    idle_after_edge();
  endtask

  task automatic wr_chk(input logic [7:0] a, input logic [31:0] d, input logic e, input string tag);
    item_t it;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; probe = 1'b1;
    it.pins = 0; it.cmp_data = 0; it.data = '0; it.err = e; it.pv = '0; it.tag = tag;
    q.push_back(it);
    idle_after_edge();
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] d, input logic e, input string tag);
    item_t it;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = '0; probe = 1'b1;
    it.pins = 0; it.cmp_data = 1; it.data = d; it.err = e; it.pv = '0; it.tag = tag;
    q.push_back(it);
    idle_after_edge();
  endtask

  task automatic pins(input logic [18:0] v, input string tag);
    item_t it;
    @(negedge clk);
    probe = 1'b1;
    it.pins = 1; it.cmp_data = 0; it.data = '0; it.err = 0; it.pv = v; it.tag = tag;
    q.push_back(it);
    idle_after_edge();
  endtask

  task automatic pulse(input logic [1:0] ev);
    @(negedge clk);
    evt_a = ev[0]; evt_h = ev[1];
    idle_after_edge();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    evt_a = 1'b0; evt_h = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    pins({1'b0, CFG_RST}, "R1 reset pins");
    rd(8'h38, 32'h20, 0, "R1 frame adj reset");
    rd(8'h48, 32'h1, 0, "R1 master enable reset");
    rd(8'h68, 32'h3, 0, "R1 mask reset");
    rd(8'h64, 32'h0, 0, "R1 status reset");
    rd(8'h60, 32'h0, 0, "R1 regctl reset");
    rd(8'h78, 32'h0, 0, "R1 spare reset");

    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, 32'h0000_000F, 0, "R2 filt reserved");
    wr(8'h34, 32'hFFFF_FFEA);
    rd(8'h34, 32'h0000_000A, 0, "R2 port reserved");
    wr(8'h38, 32'h0000_0015);
    rd(8'h38, 32'h15, 0, "R2 frame adj");
    wr(8'h40, 32'h1);
    wr(8'h44, 32'h3);
    rd(8'h44, 32'h1, 0, "R2 coherency reserved");
    wr(8'h48, 32'h0);
    pins({1'b0, CFG_NEW}, "R2 pins after writes");

    wr(8'h78, 32'hA5C3_0F96);
    rd(8'h78, 32'hA5C3_0F96, 0, "R3 spare");

    wr(8'h68, 32'h0);
    rd(8'h68, 32'h3, 0, "R7 mask write ignored");

    pulse(2'b10);
    rd(8'h64, 32'h2, 0, "R5 host event sets bit1");
    pins({1'b0, CFG_NEW}, "R8 masked event no irq");
    wr(8'h6C, 32'h2);
    rd(8'h68, 32'h1, 0, "R6 unmask bit1");
    rd(8'h6C, 32'h0, 0, "R6 unmask reads zero");
    pins({1'b1, CFG_NEW}, "R8 irq after unmask");

    wr(8'h64, 32'h1);
    rd(8'h64, 32'h2, 0, "R4 clearing other bit");
    wr(8'h64, 32'h0);
    rd(8'h64, 32'h2, 0, "R4 zero write no effect");
    wr(8'h64, 32'h2);
    rd(8'h64, 32'h0, 0, "R4 w1c clears bit1");
    pins({1'b0, CFG_NEW}, "R8 irq drops after clear");

    wr(8'h64, 32'h2, 2'b10);
    rd(8'h64, 32'h2, 0, "R5 set wins over clear");
    pins({1'b1, CFG_NEW}, "R8 irq after set-wins");
    wr(8'h64, 32'h3);

    wr(8'h70, 32'h2);
    rd(8'h68, 32'h3, 0, "R6 maskset sets bit1");
    rd(8'h70, 32'h0, 0, "R6 maskset reads zero");
    pulse(2'b10);
    pins({1'b0, CFG_NEW}, "R8 remasked event no irq");
    wr(8'h64, 32'h3);

    rd(8'h50, 32'h0, 0, "R9 unmapped no err when disabled");
    rd(8'h64, 32'h1, 0, "R9 unmapped sets bit0");
    wr(8'h6C, 32'h1);
    pins({1'b1, CFG_NEW}, "R8 decode error irq");
    wr(8'h64, 32'h1);
    wr(8'h60, 32'hFFFF_FFFF);
    rd(8'h60, 32'h1, 0, "R9 regctl mapped no err");
    rd(8'h7C, 32'h0, 1, "R9 unmapped err when enabled");
    rd(8'h32, 32'h0, 1, "R9 misaligned err");
    wr_chk(8'h20, 32'h1234_5678, 1, "R9 unmapped write err");
    rd(8'h64, 32'h1, 0, "R9 status bit0 after miss");

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule